// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the master side of a three-wire link to a 16-bit serial converter: an active-low select, a serial clock and one data line that carries bits from the converter. A one-cycle request from the host starts a read. The block lowers the select line, and that starts a conversion in the converter. It then produces a fixed frame of 24 serial clock periods with the clock idling low. It samples the data line as the clock goes high and drops the 8 padding bits that come first. It presents the remaining 16 bits together with a one-cycle valid strobe.

The serial clock comes from the system clock. A parameter gives the number of system clocks in each half period of the serial clock, and it must be chosen so that the serial clock stays at or below 4.8 MHz. After every frame, finished or not, the select line stays high for a minimum deselect gap, counted in system clocks, before another frame can begin. An abort input ends a frame at once without producing a result. A framing error flag is set when any padding bit arrives as one.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After a synchronous reset, cs_n_o is 1, sclk_o is 0, valid_o is 0, busy_o is 0, frame_err_o is 0 and data_o is 0.
- R2: A start_i pulse seen while idle, with abort_i low, drives cs_n_o low on the next clock and raises busy_o. sclk_o stays low for HALF_DIV system clocks after cs_n_o falls, and then has its first rising edge.
- R3: While cs_n_o is low, every high and low phase of sclk_o lasts exactly HALF_DIV system clocks. A complete frame has exactly 24 rising edges. sclk_o is 0 whenever cs_n_o is 1.
- R4: sdi_i is sampled at each rising edge of sclk_o, and bits arrive MSB first. The first 8 bits are discarded. Bits 9 to 24 of the frame become data_o[15] down to data_o[0].
- R5: cs_n_o rises on the same clock as the 24th falling edge of sclk_o. valid_o pulses high for exactly one clock on that same clock. data_o holds its value until the next valid_o.
- R6: frame_err_o is updated together with valid_o. It is 1 when any of the first 8 received bits was 1, and 0 otherwise, and it holds until the next valid_o.
- R7: Between the rise of cs_n_o and the next fall of cs_n_o there are at least GAP_CYC+1 system clocks. When start_i is held high, the gap is exactly GAP_CYC+1.
- R8: start_i has no effect while busy_o is high, that is, during a frame and during the deselect gap. A frame is not restarted or lengthened, and no new frame follows the gap without a fresh start_i.
- R9: When abort_i is high during a frame, cs_n_o goes high and sclk_o goes low on the next clock. No valid_o is produced, data_o and frame_err_o keep their values, and the block passes through the deselect gap before it becomes idle.
- R10: abort_i has no effect while idle. A start_i that arrives together with abort_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request for one read frame |
| abort_i | input | 1 | Ends the current frame without a result |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idles low |
| data_o | output | 16 | Last conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | A padding bit of the last frame was nonzero |
| busy_o | output | 1 | Frame or deselect gap in progress |

## Verification
The hardest case to reach is an abort that lands in the middle of a frame, after some bits have already been shifted in, followed by a check that the partial word never reaches data_o. A second hard case is a start request that falls inside the short deselect gap. The bench models the converter and counts serial clock rising edges. It raises abort_i after a chosen number of edges, and it raises start_i in the first clock after valid_o. A start held high across two frames measures the gap at its minimum.

// File: rtl/adc_rd_pkg.sv
// Shared types for the serial ADC read controller.
// Assumes: a single clock domain and synchronous active-low reset in all users.
package adc_rd_pkg;

    // Controller sequence: idle, frame in flight, deselect gap
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } rd_state_t;

endpackage

// File: rtl/adc_tick_cnt.sv
// Free-running interval counter used for the serial clock half period and
// for the deselect gap. While run_i is high it raises tick_o once every
// LIMIT clocks, and the first tick comes LIMIT clocks after run_i rises.
// Assumes: LIMIT >= 1; the count restarts from zero whenever run_i is low.
module adc_tick_cnt #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks while running; wrap at the interval end, clear when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/adc_rx_shift.sv
// Receive shift register for one frame. Each smp_i pulse shifts bit_i in at
// the LSB end, so the first bit received ends up at the MSB. full_o is high
// once FRAME_W bits have been taken.
// Assumes: clr_i is held between frames; no more than FRAME_W samples per frame.
module adc_rx_shift #(
    parameter int unsigned FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               smp_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] word_o,
    output logic               full_o
);
    localparam int unsigned BCW = $clog2(FRAME_W + 1);
    localparam logic [BCW-1:0] FULL_CNT = BCW'(FRAME_W);

    logic [FRAME_W-1:0] word_q;
    logic [BCW-1:0]     bits_q;

    // Shift in sampled bits and count them; clear between frames
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            word_q <= '0;
            bits_q <= '0;
        end else if (smp_i) begin
            word_q <= {word_q[FRAME_W-2:0], bit_i};
            bits_q <= bits_q + 1'b1;
        end
    end

    assign word_o = word_q;
    assign full_o = (bits_q == FULL_CNT);

    // R3: the controller never asks for a 25th sample in a frame
    p_no_extra_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_i |-> !full_o);

endmodule

// File: rtl/adc_rd_ctrl.sv
// Serial ADC read controller (top). A start request lowers the select line,
// produces PAD_W+RES_W serial clock periods in mode 0 (clock idles low,
// samples taken as the clock rises), drops the PAD_W padding bits and
// presents RES_W result bits with a one-cycle valid strobe. A deselect gap of
// GAP_CYC clocks plus one idle clock follows every frame, including aborted ones.
// Assumes: HALF_DIV chosen so that f_clk / (2*HALF_DIV) <= 4.8 MHz, and
// GAP_CYC system clocks span at least 50 ns.
module adc_rd_ctrl #(
    parameter int unsigned HALF_DIV = 11,
    parameter int unsigned GAP_CYC  = 5,
    parameter int unsigned RES_W    = 16,
    parameter int unsigned PAD_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             sdi_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic [RES_W-1:0] data_o,
    output logic             valid_o,
    output logic             frame_err_o,
    output logic             busy_o
);
    import adc_rd_pkg::*;

    localparam int unsigned FRAME_W = RES_W + PAD_W;
    localparam int unsigned RCW     = $clog2(FRAME_W + 1) + 1;
    localparam int unsigned HI_MAX  = GAP_CYC + 1;
    localparam int unsigned HCW     = $clog2(HI_MAX + 1) + 1;

    rd_state_t          state_q;
    logic               cs_n_q;
    logic               sclk_q;
    logic               valid_q;
    logic               err_q;
    logic [RES_W-1:0]   data_q;

    logic               half_tick;
    logic               gap_done;
    logic               smp;
    logic               rx_full;
    logic [FRAME_W-1:0] rx_word;

    // Serial clock half-period timer runs only during a frame
    adc_tick_cnt #(.LIMIT(HALF_DIV)) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_XFER),
        .tick_o (half_tick)
    );

    // Deselect gap timer runs only in the gap state
    adc_tick_cnt #(.LIMIT(GAP_CYC)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_GAP),
        .tick_o (gap_done)
    );

    // Sample on the tick that raises the serial clock, unless aborting
    assign smp = (state_q == ST_XFER) && half_tick && !sclk_q && !abort_i;

    adc_rx_shift #(.FRAME_W(FRAME_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q != ST_XFER),
        .smp_i  (smp),
        .bit_i  (sdi_i),
        .word_o (rx_word),
        .full_o (rx_full)
    );

    // Sequence control: select, serial clock, result capture and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i && !abort_i) begin
                        state_q <= ST_XFER;
                        cs_n_q  <= 1'b0;
                    end
                end
                ST_XFER: begin
                    if (abort_i) begin
                        state_q <= ST_GAP;
                        cs_n_q  <= 1'b1;
                        sclk_q  <= 1'b0;
                    end else if (half_tick) begin
                        if (sclk_q && rx_full) begin
                            state_q <= ST_GAP;
                            cs_n_q  <= 1'b1;
                            sclk_q  <= 1'b0;
                            valid_q <= 1'b1;
                            data_q  <= rx_word[RES_W-1:0];
                            err_q   <= |rx_word[FRAME_W-1:RES_W];
                        end else begin
                            sclk_q <= !sclk_q;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cs_n_q  <= 1'b1;
                    sclk_q  <= 1'b0;
                end
            endcase
        end
    end

    assign cs_n_o      = cs_n_q;
    assign sclk_o      = sclk_q;
    assign valid_o     = valid_q;
    assign data_o      = data_q;
    assign frame_err_o = err_q;
    assign busy_o      = (state_q != ST_IDLE);

    // ---------------- checking logic ----------------
    logic           sclk_d;
    logic [RCW-1:0] rise_cnt;
    logic [HCW-1:0] hi_cnt;

    // Track previous serial clock level, rises per frame and select-high length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
            hi_cnt   <= HCW'(HI_MAX);
        end else begin
            sclk_d   <= sclk_q;
            rise_cnt <= cs_n_q ? '0 : rise_cnt + RCW'(sclk_q && !sclk_d);
            if (!cs_n_q) begin
                hi_cnt <= '0;
            end else if (hi_cnt != HCW'(HI_MAX)) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    // R3: the serial clock is low whenever the converter is deselected
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sclk_q);

    // R3: a completed frame carried exactly FRAME_W rising edges
    p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (rise_cnt == RCW'(FRAME_W)));

    // R2: a frame opens with the serial clock low
    p_open_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_q) |-> !sclk_q);

    // R5: the strobe comes with the deselect edge
    p_valid_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $rose(cs_n_q));

    // R7: the select line stayed high for the full deselect gap
    p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_q) |-> (hi_cnt >= HCW'(HI_MAX)));

    // R8: no frame can open while the gap is running
    p_gap_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |=> cs_n_q);

    // R9: an abort mid-frame deselects at once and gives no strobe
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_XFER) && abort_i) |=> (cs_n_q && !sclk_q && !valid_q));

    // R10: an abort while idle keeps the converter deselected
    p_idle_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && abort_i) |=> cs_n_q);

endmodule

// File: tb/sim_adc_rd_ctrl.sv
// Directed bench for adc_rd_ctrl with a behavioural converter model.
module sim_adc_rd_ctrl;
    localparam int CLK_PER  = 10;
    localparam int HALF_DIV = 11;
    localparam int GAP_CYC  = 5;
    localparam int RES_W    = 16;
    localparam int FW       = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic abort = 1'b0;
    logic sdi = 1'b0;
    logic cs_n, sclk, valid, ferr, busy;
    logic [RES_W-1:0] data;

    int checks = 0;
    int errs   = 0;

    adc_rd_ctrl #(.HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort), .sdi_i(sdi),
        .cs_n_o(cs_n), .sclk_o(sclk), .data_o(data), .valid_o(valid),
        .frame_err_o(ferr), .busy_o(busy)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Converter model and edge monitor, evaluated away from the active edge
    logic [FW-1:0] slv_word = '0;
    int cyc = 0, rises = 0, t_csf = 0, t_csr = 0, t_r1 = 0, t_f1 = 0;
    int gap_meas = 0, vcnt = 0, csr_bad = 0, vwide = 0, bitpos = 0;
    logic pcs = 1'b1, psclk = 1'b0, pvalid = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pcs && !cs_n) begin
            t_csf = cyc; rises = 0; gap_meas = cyc - t_csr;
            bitpos = FW - 1; sdi = slv_word[FW-1];
        end
        if (!pcs && cs_n) t_csr = cyc;
        if (!cs_n && !psclk && sclk) begin
            rises = rises + 1;
            if (rises == 1) t_r1 = cyc;
        end
        if (!cs_n && psclk && !sclk) begin
            if (rises == 1) t_f1 = cyc;
            if (bitpos > 0) begin
                bitpos = bitpos - 1;
                sdi = slv_word[bitpos];
            end
        end
        if (valid) begin
            vcnt = vcnt + 1;
            if (!(!pcs && cs_n)) csr_bad = csr_bad + 1;
            if (pvalid) vwide = vwide + 1;
        end
        pcs = cs_n; psclk = sclk; pvalid = valid;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_start();
        start = 1'b1; step(); start = 1'b0;
    endtask

    task automatic wait_valid(input int v0);
        for (int i = 0; i < 2000 && vcnt == v0; i++) step();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) step();
    endtask

    // R2..R6: one full frame with result and timing checks
    task automatic t_frame(input logic [FW-1:0] w);
        int v0;
        slv_word = w; v0 = vcnt;
        pulse_start();
        check(!cs_n && busy, "R2 select low and busy", {cs_n, busy}, 2'b01);
        wait_valid(v0);
        check(vcnt == v0 + 1, "R5 one valid", vcnt - v0, 1);
        check(data == w[15:0], "R4 data", data, w[15:0]);
        check(ferr == (|w[23:16]), "R6 pad error flag", ferr, |w[23:16]);
        check(rises == FW, "R3 rising edges", rises, FW);
        check(t_r1 - t_csf == HALF_DIV, "R2 select to first rise", t_r1 - t_csf, HALF_DIV);
        check(t_f1 - t_r1 == HALF_DIV, "R3 high phase", t_f1 - t_r1, HALF_DIV);
        wait_idle();
        check(data == w[15:0] && cs_n && !sclk, "R5 data held after frame", data, w[15:0]);
    endtask

    // R1: state after reset
    task automatic t_reset();
        check(cs_n && !sclk && !valid && !busy && !ferr && data == 0,
              "R1 reset outputs", {cs_n, sclk, valid, busy, ferr}, 5'b10000);
    endtask

    // R7, R8: start held high across two frames
    task automatic t_back_to_back();
        int v0;
        slv_word = 24'h00_3C5A; v0 = vcnt;
        start = 1'b1;
        wait_valid(v0);
        for (int i = 0; i < 50 && cs_n; i++) step();
        start = 1'b0;
        check(gap_meas == GAP_CYC + 1, "R7 minimum gap", gap_meas, GAP_CYC + 1);
        check(vcnt == v0 + 1, "R8 held start gave one result per frame", vcnt - v0, 1);
        wait_valid(v0 + 1);
        check(data == 16'h3C5A, "R7 second frame data", data, 16'h3C5A);
        wait_idle();
    endtask

    // R8: start during a frame and during the gap is ignored
    task automatic t_start_ignored();
        int v0;
        slv_word = 24'h00_1357; v0 = vcnt;
        pulse_start();
        for (int i = 0; i < 2000 && rises < 5; i++) step();
        pulse_start();
        wait_valid(v0);
        check(rises == FW && vcnt == v0 + 1, "R8 mid-frame start ignored", rises, FW);
        pulse_start();
        for (int i = 0; i < GAP_CYC + 10; i++) begin
            step();
            if (!cs_n) break;
        end
        check(cs_n && !busy, "R8 gap start ignored", {cs_n, busy}, 2'b10);
    endtask

    // R9: abort in the middle of a frame
    task automatic t_abort();
        int v0;
        logic [15:0] d0;
        logic e0;
        d0 = data; e0 = ferr; v0 = vcnt;
        slv_word = 24'hFF_7777;
        pulse_start();
        for (int i = 0; i < 2000 && rises < 10; i++) step();
        abort = 1'b1; step(); abort = 1'b0;
        check(cs_n && !sclk, "R9 abort deselects", {cs_n, sclk}, 2'b10);
        check(busy, "R9 gap after abort", busy, 1);
        wait_idle();
        for (int i = 0; i < 20; i++) step();
        check(vcnt == v0, "R9 no valid on abort", vcnt - v0, 0);
        check(data == d0 && ferr == e0, "R9 result kept", data, d0);
    endtask

    // R10: abort while idle, and start together with abort
    task automatic t_idle_abort();
        abort = 1'b1; start = 1'b1; step();
        abort = 1'b0; start = 1'b0; step();
        check(cs_n && !busy, "R10 start with abort ignored", {cs_n, busy}, 2'b10);
        abort = 1'b1; step(); abort = 1'b0; step();
        check(cs_n && !busy && !sclk, "R10 idle abort no effect", {cs_n, busy}, 2'b10);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_frame(24'h00_A5C3);
        t_frame(24'h00_FFFF);
        t_frame(24'h00_0000);
        t_frame(24'h00_8001);
        t_frame(24'h01_1234);
        t_frame(24'h80_0000);
        t_frame(24'h00_4321);
        t_back_to_back();
        t_start_ignored();
        t_abort();
        t_idle_abort();
        t_frame(24'h00_BEEF);
        check(csr_bad == 0, "R5 valid with deselect", csr_bad, 0);
        check(vwide == 0, "R5 valid one clock", vwide, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule